// File: doc/BRIEF.md
# DMA Channel Byte-Count and Status Register

This block holds the remaining-byte counter and the status flags of one DMA channel, both packed into a single 32-bit word. Software reads the word, loads a byte count, and writes a one to the done bit to return the channel to idle. A data mover outside this block sends one pulse for each completed write beat, together with that beat's size. The counter goes down by the size of each beat. When the counter reaches zero, the channel reports completion.

A start request first checks that the count is aligned to the chosen access size. A misaligned count moves the channel into a configuration-error state, and no transfer begins. An aligned, non-zero count moves it into the busy state. While busy, the block raises a transfer-permit output for the data mover.

The control is a four-state machine:
- **IDLE**: waiting for a start.
- **BUSY**: transfer in progress.
- **DONE**: block complete.
- **ERR**: configuration error.

The transitions are:
- **IDLE→BUSY**: start with an aligned, non-zero count.
- **IDLE→ERR**: start with a misaligned count.
- **IDLE→DONE**: start with a zero count.
- **BUSY→DONE**: the beat that empties the counter.
- **any→IDLE**: software clear, which is a write with the done bit set.

Top module: `dma_cnt_status`

## Requirements
- R1: The read word carries status in bits 31–24 and the count in bits 23–0. Status bit 24 is done, bit 25 is busy, bit 30 is configuration error, and every other status bit reads zero.
- R2: After reset the whole word reads zero and the transfer-permit output is low.
- R3: In BUSY, each beat pulse lowers the count by 1, 2 or 4, for size codes 0 (8-bit), 1 (16-bit) and 2 (32-bit). Size code 3 acts as 32-bit.
- R4: A write with bit 24 set clears the count to zero and returns the channel to IDLE from any state, including BUSY. The data in bits 23–0 of that write is not loaded.
- R5: The beat that brings the count to zero sets done and clears busy on the same clock edge.
- R6: A start in IDLE sets the configuration-error flag, begins no transfer and leaves the count unchanged when either of these holds: the size is 32-bit and the count is not a multiple of 4, or the size is 16-bit and the count is odd.
- R7: A write with bit 24 clear loads bits 23–0 as the new count only when the channel is not BUSY. During BUSY such a write is ignored. Written values of status bits other than bit 24 never appear in the status.
- R8: Transfer-permit is high exactly when the channel is busy, the count is non-zero and no configuration error is set.
- R9: When a clear write and the final beat fall in the same cycle, the clear wins: the channel ends in IDLE with done low.
- R10: A start is acted on only in IDLE, and only in a cycle with no register write. A beat pulse has an effect only in BUSY.
- R11: A start in IDLE with a zero count moves straight to DONE, and transfer-permit stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data: status and count |
| start | input | 1 | Start request pulse |
| beat_size | input | 2 | Access size code: 0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit |
| beat_done | input | 1 | One pulse per completed write beat |
| xfer_permit | output | 1 | Channel may move data |

## Verification
The hardest case to reach from the ports is a software clear landing in the same cycle as the beat that would empty the counter. The stimulus loads a count equal to one beat, starts the transfer, and then drives the clear write and the beat pulse together in one cycle. A nearby case is a count write issued during a transfer, when the beat pulse is idle, so that only the write-ignore rule applies. The bench also starts the channel with misaligned counts for each access size, and mixes sizes within one transfer, to cover the decrement widths.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2,
        ST_ERR  = 2'd3
    } chan_state_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WALT = 2'd3
    } beat_size_e;
endpackage

// File: rtl/dcs_align.sv
module dcs_align
    import dcs_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic [1:0]       size,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] step,
    output logic             misalign
);
    beat_size_e sz;

    always_comb begin
        sz = beat_size_e'(size);
        step = '0;
        misalign = 1'b0;
        unique case (sz)
            SZ_BYTE: begin
                step = CNT_W'(1);
            end
            SZ_HALF: begin
                step = CNT_W'(2);
                misalign = cnt[0];
            end
            SZ_WORD, SZ_WALT: begin
                step = CNT_W'(4);
                misalign = |cnt[1:0];
            end
        endcase
    end
endmodule

// File: rtl/dcs_counter.sv
module dcs_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load_req,
    input  logic             busy,
    input  logic             beat,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] step,
    output logic [CNT_W-1:0] cnt_q
);
    logic dec_en;
    logic load_en;

    assign dec_en  = beat && busy;
    assign load_en = load_req && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (load_en) begin
            cnt_q <= load_val;
        end else if (dec_en) begin
            cnt_q <= cnt_q - step;
        end
    end

    assert_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && !clr) |=> (cnt_q == $past(cnt_q) - $past(step)));

    assert_clear_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

    assert_busy_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && load_req && !clr && !beat) |=> $stable(cnt_q));
endmodule

// File: rtl/dcs_fsm.sv
module dcs_fsm
    import dcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic start_ok,
    input  logic misalign,
    input  logic cnt_zero,
    input  logic last_beat,
    output logic busy,
    output logic done,
    output logic cfg_err
);
    chan_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_ok) begin
                    if (misalign)      state_d = ST_ERR;
                    else if (cnt_zero) state_d = ST_DONE;
                    else               state_d = ST_BUSY;
                end
                ST_BUSY: if (last_beat) state_d = ST_DONE;
                ST_DONE: state_d = ST_DONE;
                ST_ERR:  state_d = ST_ERR;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        busy    = (state_q == ST_BUSY);
        done    = (state_q == ST_DONE);
        cfg_err = (state_q == ST_ERR);
    end

    assert_misalign_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_ok && !clr && misalign) |=> (state_q == ST_ERR));

    assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (state_q == ST_IDLE));

    assert_start_only_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERR && !clr) |=> (state_q == ST_ERR));
endmodule

// File: rtl/dma_cnt_status.sv
module dma_cnt_status #(
    parameter int CNT_W    = 24,
    parameter int STAT_W   = 8,
    parameter int DONE_POS = 0,
    parameter int BUSY_POS = 1,
    parameter int ERR_POS  = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic [CNT_W+STAT_W-1:0] reg_wdata,
    output logic [CNT_W+STAT_W-1:0] reg_rdata,
    input  logic                    start,
    input  logic [1:0]              beat_size,
    input  logic                    beat_done,
    output logic                    xfer_permit
);
    localparam int WORD_W = CNT_W + STAT_W;

    logic             clr;
    logic             start_ok;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] step;
    logic             misalign;
    logic             cnt_zero;
    logic             last_beat;
    logic             busy, done, cfg_err;
    logic [STAT_W-1:0] status;

    assign clr       = reg_wr && reg_wdata[CNT_W + DONE_POS];
    assign start_ok  = start && !reg_wr;
    assign cnt_zero  = (cnt_q == '0);
    assign last_beat = beat_done && (cnt_q <= step);

    dcs_align #(.CNT_W(CNT_W)) u_align (
        .size     (beat_size),
        .cnt      (cnt_q),
        .step     (step),
        .misalign (misalign)
    );

    dcs_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .load_req (reg_wr),
        .busy     (busy),
        .beat     (beat_done),
        .load_val (reg_wdata[CNT_W-1:0]),
        .step     (step),
        .cnt_q    (cnt_q)
    );

    dcs_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .start_ok  (start_ok),
        .misalign  (misalign),
        .cnt_zero  (cnt_zero),
        .last_beat (last_beat),
        .busy      (busy),
        .done      (done),
        .cfg_err   (cfg_err)
    );

    always_comb begin
        status           = '0;
        status[DONE_POS] = done;
        status[BUSY_POS] = busy;
        status[ERR_POS]  = cfg_err;
    end

    assign reg_rdata   = WORD_W'({status, cnt_q});
    assign xfer_permit = busy && !cnt_zero && !cfg_err;

    assert_done_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> cnt_zero);

    assert_done_drops_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && last_beat && !clr) |=> (done && !busy));

    assert_permit_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_permit && beat_done && !clr && !last_beat) |=> xfer_permit);
endmodule

// File: tb/tb_dma_cnt_status.sv
module tb_dma_cnt_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        start = 1'b0;
    logic [1:0]  beat_size = '0;
    logic        beat_done = 1'b0;
    logic        xfer_permit;

    always #4 clk = ~clk;

    dma_cnt_status dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .start(start), .beat_size(beat_size),
        .beat_done(beat_done), .xfer_permit(xfer_permit)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [32:0] exp_q[$];
    string       tag_q[$];

    // bench model: 0 idle, 1 busy, 2 done, 3 error
    int          m_st = 0;
    logic [23:0] m_cnt = '0;

    task automatic cyc(input bit w, input logic [31:0] wd, input bit s,
                       input logic [1:0] sz, input bit b, input string tag);
        logic [23:0] stp;
        bit          mis;
        int          nst;
        logic [23:0] ncnt;
        logic [7:0]  st_byte;
        @(negedge clk);
        reg_wr = w; reg_wdata = wd; start = s; beat_size = sz; beat_done = b;
        @(posedge clk);
        stp = (sz == 2'd0) ? 24'd1 : (sz == 2'd1) ? 24'd2 : 24'd4;
        mis = (sz >= 2'd2 && m_cnt[1:0] != 2'b00) || (sz == 2'd1 && m_cnt[0]);
        nst = m_st; ncnt = m_cnt;
        if (w && wd[24]) begin
            nst = 0; ncnt = '0;
        end else begin
            if (w && m_st != 1) ncnt = wd[23:0];
            if (b && m_st == 1) begin
                ncnt = m_cnt - stp;
                if (m_cnt <= stp) nst = 2;
            end
            if (m_st == 0 && s && !w) nst = mis ? 3 : (m_cnt == 0 ? 2 : 1);
        end
        m_st = nst; m_cnt = ncnt;
        st_byte = '0;
        st_byte[0] = (m_st == 2);
        st_byte[1] = (m_st == 1);
        st_byte[6] = (m_st == 3);
        exp_q.push_back({(m_st == 1 && m_cnt != 0), st_byte, m_cnt});
        tag_q.push_back(tag);
    endtask

    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [32:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            if ({xfer_permit, reg_rdata} !== e) begin
                n_fail++;
                $display("FAIL %s: got rdata=%h permit=%b, expected rdata=%h permit=%b",
                         t, reg_rdata, xfer_permit, e[31:0], e[32]);
            end
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc(0, 32'h0, 0, 2'd0, 0, "R2");                 // reset state
        cyc(1, 32'hFE00_000C, 0, 2'd0, 0, "R7");         // load 12, junk status ignored
        cyc(0, 32'h0, 1, 2'd2, 0, "R1");                 // start 32-bit -> busy
        cyc(0, 32'h0, 0, 2'd2, 1, "R3");                 // 12 -> 8
        cyc(0, 32'h0, 0, 2'd2, 1, "R8");                 // 8 -> 4, permit high
        cyc(1, 32'h0000_0055, 0, 2'd2, 0, "R7");         // write during busy ignored
        cyc(0, 32'h0, 0, 2'd2, 1, "R5");                 // 4 -> 0, done
        cyc(0, 32'h0, 0, 2'd2, 1, "R10");                // beat in done ignored
        cyc(0, 32'h0, 1, 2'd2, 0, "R10");                // start in done ignored
        cyc(1, 32'h0100_0000, 0, 2'd0, 0, "R4");         // clear -> idle
        cyc(1, 32'h0000_0007, 0, 2'd0, 0, "R7");         // load 7
        cyc(0, 32'h0, 1, 2'd1, 0, "R6");                 // odd count 16-bit -> error
        cyc(0, 32'h0, 0, 2'd1, 1, "R10");                // beat in error ignored
        cyc(1, 32'h0100_0000, 0, 2'd0, 0, "R4");         // clear error
        cyc(1, 32'h0000_0006, 0, 2'd0, 0, "R7");         // load 6
        cyc(0, 32'h0, 1, 2'd2, 0, "R6");                 // 6 not multiple of 4 -> error
        cyc(1, 32'h0100_0000, 0, 2'd0, 0, "R4");
        cyc(1, 32'h0000_0006, 0, 2'd0, 0, "R7");
        cyc(0, 32'h0, 1, 2'd1, 0, "R8");                 // 16-bit aligned -> busy
        cyc(0, 32'h0, 0, 2'd1, 1, "R3");                 // 6 -> 4
        cyc(0, 32'h0, 0, 2'd1, 1, "R3");                 // 4 -> 2
        cyc(0, 32'h0, 0, 2'd0, 1, "R3");                 // byte: 2 -> 1
        cyc(0, 32'h0, 0, 2'd0, 1, "R5");                 // 1 -> 0 done
        cyc(1, 32'h0100_0000, 0, 2'd0, 0, "R4");
        cyc(1, 32'h0000_0008, 0, 2'd0, 0, "R7");
        cyc(1, 32'h0000_0008, 1, 2'd3, 0, "R10");        // start with write dropped
        cyc(0, 32'h0, 1, 2'd3, 0, "R8");                 // size 3 start -> busy
        cyc(0, 32'h0, 0, 2'd3, 1, "R3");                 // size 3 acts 32-bit: 8 -> 4
        cyc(1, 32'h0100_0000, 0, 2'd2, 1, "R9");         // clear + final beat: clear wins
        cyc(0, 32'h0, 1, 2'd2, 0, "R11");                // zero count start -> done
        cyc(1, 32'h0100_0000, 0, 2'd0, 0, "R4");
        cyc(1, 32'h0000_0010, 0, 2'd0, 0, "R7");
        cyc(0, 32'h0, 1, 2'd2, 0, "R8");
        cyc(1, 32'h0100_0ABC, 0, 2'd0, 0, "R4");         // clear mid-transfer, data not loaded
        cyc(1, 32'h0000_0003, 0, 2'd0, 0, "R7");
        cyc(0, 32'h0, 1, 2'd0, 0, "R1");                 // byte size, any count aligned
        cyc(0, 32'h0, 0, 2'd0, 1, "R3");
        cyc(0, 32'h0, 0, 2'd0, 0, "R8");
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule